// File: doc/BRIEF.md
# Banked General-Purpose Register File

This block holds four complete register banks for a 64-bit core. Each bank has 32 general registers plus its own copies of four control registers: the return link, the global data base, the trap table base and the stack pointer. A two-bit field inside a 32-bit status register picks the active bank. Interrupts and system calls can then switch context by changing that field, and no registers need to be saved to memory.

The pipeline reads two general registers and one control register of the active bank, and writes one general and one control register of the active bank. A side port reaches any entry of any bank. Its entry number comes from an instruction immediate, so privileged code can move values between banks. Trap entry saves the status register into an exception copy and selects the interrupt bank or the system-call bank. Trap return restores the status register from that copy.

All ports are plain control and data pins. The block has no streaming interface, so no valid/ready handshake and no back-pressure. Every request is taken in the cycle it is presented.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every entry of every bank reads 0, the status register and its exception copy are 0, and bank 0 is active.
- R2: The active bank is status bits 19:18. `rd_a_data` and `rd_b_data` show general register `rd_a_idx` / `rd_b_idx` of the active bank in the same cycle. A write with `wr_en` becomes visible after the next rising clock edge.
- R3: Control registers are banked, with codes 0 link, 1 global base, 2 trap base, 3 stack pointer. `ctl_rd_data` shows the active bank's copy of the register coded `ctl_rd_sel`. `ctl_wr_en` writes the active bank's copy at the clock edge.
- R4: Side port entry codes 0..31 are general registers and 32..35 are link, global base, trap base and stack pointer, in bank `side_*_bank`. Reads are combinational and writes take effect at the clock edge. Codes 36..63 read 0, and a side write with such a code changes nothing.
- R5: A side access whose bank equals the active bank reads and writes the same storage as the normal ports.
- R6: If a normal write (general or control) and a side write hit the same entry in the same cycle, the normal write's data is stored.
- R7: A status write with `priv_ok` low updates every bit except 19:18, which keep their value. With `priv_ok` high, all bits are written.
- R8: On `trap_enter`, the exception copy takes the current status value. Status bits 19:18 become 3 when `trap_irq` is high and 2 when it is low. All other status bits are kept.
- R9: On `trap_return`, the status register takes the exception copy's value. When requests coincide, `trap_enter` wins over `trap_return`, and `trap_return` wins over a status write.
- R10: A normal write in the same cycle as a bank change commits to the bank that was active before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Read port A register number |
| rd_a_data | output | 64 | Read port A data |
| rd_b_idx | input | 5 | Read port B register number |
| rd_b_data | output | 64 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 5 | General register write number |
| wr_data | input | 64 | General register write data |
| ctl_rd_sel | input | 2 | Control register read code |
| ctl_rd_data | output | 64 | Control register read data |
| ctl_wr_en | input | 1 | Control register write enable |
| ctl_wr_sel | input | 2 | Control register write code |
| ctl_wr_data | input | 64 | Control register write data |
| side_rd_bank | input | 2 | Side read bank |
| side_rd_sel | input | 6 | Side read entry code |
| side_rd_data | output | 64 | Side read data |
| side_wr_en | input | 1 | Side write enable |
| side_wr_bank | input | 2 | Side write bank |
| side_wr_sel | input | 6 | Side write entry code |
| side_wr_data | input | 64 | Side write data |
| sr_wr_en | input | 1 | Status register write enable |
| sr_wr_data | input | 32 | Status register write data |
| priv_ok | input | 1 | High in interrupt or context-switch state |
| trap_enter | input | 1 | Trap entry request |
| trap_irq | input | 1 | Trap entry is an interrupt (else a system call) |
| trap_return | input | 1 | Trap return request |
| sr_q | output | 32 | Status register |
| exsr_q | output | 32 | Exception-saved status register |
| active_bank | output | 2 | Active bank number |

## Verification
The read ports are combinational, so reads have zero latency. The bench changes the read selects one time unit after a rising edge and samples two units later, in the same cycle. Writes, status updates, trap entry and trap return appear one edge later. Each of these stimuli is held for exactly one cycle, and its result is sampled one time unit after that edge, before any new stimulus is applied. Bank contents are tracked by a model that the bench updates at the point where each write is due. The bank behaviour is then checked by sweeping every entry of every bank through both the side port and the normal ports.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int NUM_BANK = 4;
  localparam int BANK_W   = 2;
  localparam int BANK_LO  = 18;
  localparam int NUM_CTL  = 4;
  localparam logic [BANK_W-1:0] BANK_SYS = 2'd2;
  localparam logic [BANK_W-1:0] BANK_IRQ = 2'd3;

  typedef enum logic [1:0] {
    CTL_LINK  = 2'd0,
    CTL_GBASE = 2'd1,
    CTL_TBASE = 2'd2,
    CTL_SP    = 2'd3
  } ctl_sel_e;
endpackage

// File: rtl/brf_status.sv
module brf_status
  import brf_pkg::*;
#(
  parameter int SRW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sr_wr_en,
  input  logic [SRW-1:0] sr_wr_data,
  input  logic           priv_ok,
  input  logic           trap_enter,
  input  logic           trap_irq,
  input  logic           trap_return,
  output logic [SRW-1:0] sr_q,
  output logic [SRW-1:0] exsr_q
);
  localparam int BANK_HI = BANK_LO + BANK_W - 1;
  localparam logic [SRW-1:0] BANK_MASK = SRW'({BANK_W{1'b1}}) << BANK_LO;

  logic [SRW-1:0] sr_guarded;
  logic [SRW-1:0] sr_trap;

  always_comb begin
    sr_guarded = priv_ok ? sr_wr_data
                         : ((sr_wr_data & ~BANK_MASK) | (sr_q & BANK_MASK));
    sr_trap = sr_q;
    sr_trap[BANK_HI:BANK_LO] = trap_irq ? BANK_IRQ : BANK_SYS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= '0;
      exsr_q <= '0;
    end else if (trap_enter) begin
      exsr_q <= sr_q;
      sr_q   <= sr_trap;
    end else if (trap_return) begin
      sr_q <= exsr_q;
    end else if (sr_wr_en) begin
      sr_q <= sr_guarded;
    end
  end
endmodule

// File: rtl/brf_bank.sv
module brf_bank #(
  parameter int          XLEN = 64,
  parameter int          NENT = 36,
  parameter int          SELW = 6,
  parameter int          BW   = 2,
  parameter logic [1:0]  ID   = 2'd0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BW-1:0]             act_bank,
  input  logic                      gpr_we,
  input  logic [SELW-1:0]           gpr_ent,
  input  logic [XLEN-1:0]           gpr_wd,
  input  logic                      ctl_we,
  input  logic [SELW-1:0]           ctl_ent,
  input  logic [XLEN-1:0]           ctl_wd,
  input  logic                      side_we,
  input  logic [BW-1:0]             side_bank,
  input  logic [SELW-1:0]           side_ent,
  input  logic [XLEN-1:0]           side_wd,
  output logic [NENT-1:0][XLEN-1:0] regs_o
);
  logic own_act;
  logic own_side;

  assign own_act  = (act_bank == ID[BW-1:0]);
  assign own_side = (side_bank == ID[BW-1:0]);

  always_ff @(posedge clk) begin
    for (int e = 0; e < NENT; e++) begin
      if (!rst_n)
        regs_o[e] <= '0;
      else if (gpr_we && own_act && gpr_ent == SELW'(e))
        regs_o[e] <= gpr_wd;
      else if (ctl_we && own_act && ctl_ent == SELW'(e))
        regs_o[e] <= ctl_wd;
      else if (side_we && own_side && side_ent == SELW'(e))
        regs_o[e] <= side_wd;
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter int SRW  = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [$clog2(NREG)-1:0]         rd_a_idx,
  output logic [XLEN-1:0]                 rd_a_data,
  input  logic [$clog2(NREG)-1:0]         rd_b_idx,
  output logic [XLEN-1:0]                 rd_b_data,
  input  logic                            wr_en,
  input  logic [$clog2(NREG)-1:0]         wr_idx,
  input  logic [XLEN-1:0]                 wr_data,
  input  logic [1:0]                      ctl_rd_sel,
  output logic [XLEN-1:0]                 ctl_rd_data,
  input  logic                            ctl_wr_en,
  input  logic [1:0]                      ctl_wr_sel,
  input  logic [XLEN-1:0]                 ctl_wr_data,
  input  logic [1:0]                      side_rd_bank,
  input  logic [$clog2(NREG+4)-1:0]       side_rd_sel,
  output logic [XLEN-1:0]                 side_rd_data,
  input  logic                            side_wr_en,
  input  logic [1:0]                      side_wr_bank,
  input  logic [$clog2(NREG+4)-1:0]       side_wr_sel,
  input  logic [XLEN-1:0]                 side_wr_data,
  input  logic                            sr_wr_en,
  input  logic [SRW-1:0]                  sr_wr_data,
  input  logic                            priv_ok,
  input  logic                            trap_enter,
  input  logic                            trap_irq,
  input  logic                            trap_return,
  output logic [SRW-1:0]                  sr_q,
  output logic [SRW-1:0]                  exsr_q,
  output logic [1:0]                      active_bank
);
  localparam int NENT = NREG + NUM_CTL;
  localparam int SELW = $clog2(NENT);

  logic [NENT-1:0][XLEN-1:0] bank_regs [NUM_BANK];
  logic [SELW-1:0] ctl_rd_ent, ctl_wr_ent, side_rd_ent;
  logic            side_rd_ok, side_wr_ok;

  brf_status #(.SRW(SRW)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .sr_wr_en   (sr_wr_en),
    .sr_wr_data (sr_wr_data),
    .priv_ok    (priv_ok),
    .trap_enter (trap_enter),
    .trap_irq   (trap_irq),
    .trap_return(trap_return),
    .sr_q       (sr_q),
    .exsr_q     (exsr_q)
  );

  assign active_bank = sr_q[BANK_LO +: BANK_W];
  assign ctl_rd_ent  = SELW'(NREG) + SELW'(ctl_rd_sel);
  assign ctl_wr_ent  = SELW'(NREG) + SELW'(ctl_wr_sel);
  assign side_rd_ok  = (side_rd_sel < SELW'(NENT));
  assign side_wr_ok  = (side_wr_sel < SELW'(NENT));
  assign side_rd_ent = side_rd_ok ? side_rd_sel : '0;

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    brf_bank #(
      .XLEN(XLEN), .NENT(NENT), .SELW(SELW), .BW(BANK_W), .ID(2'(b))
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_bank (active_bank),
      .gpr_we   (wr_en),
      .gpr_ent  (SELW'(wr_idx)),
      .gpr_wd   (wr_data),
      .ctl_we   (ctl_wr_en),
      .ctl_ent  (ctl_wr_ent),
      .ctl_wd   (ctl_wr_data),
      .side_we  (side_wr_en && side_wr_ok),
      .side_bank(side_wr_bank),
      .side_ent (side_wr_sel),
      .side_wd  (side_wr_data),
      .regs_o   (bank_regs[b])
    );
  end

  always_comb begin
    rd_a_data    = bank_regs[active_bank][SELW'(rd_a_idx)];
    rd_b_data    = bank_regs[active_bank][SELW'(rd_b_idx)];
    ctl_rd_data  = bank_regs[active_bank][ctl_rd_ent];
    side_rd_data = side_rd_ok ? bank_regs[side_rd_bank][side_rd_ent] : '0;
  end
endmodule

// File: rtl/brf_checker.sv
module brf_checker #(
  parameter int SRW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sr_wr_en,
  input logic           priv_ok,
  input logic           trap_enter,
  input logic           trap_irq,
  input logic           trap_return,
  input logic [SRW-1:0] sr_q,
  input logic [SRW-1:0] exsr_q,
  input logic [1:0]     active_bank
);
  AST_TRAP_IRQ_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter && trap_irq |=> active_bank == 2'd3); // R8
  AST_TRAP_SYS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter && !trap_irq |=> active_bank == 2'd2); // R8
  AST_TRAP_SAVES_SR: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter |=> exsr_q == $past(sr_q)); // R8
  AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    trap_return && !trap_enter |=> sr_q == $past(exsr_q)); // R9
  AST_BANK_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_en && !priv_ok && !trap_enter && !trap_return
      |=> active_bank == $past(active_bank)); // R7
  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_wr_en && !trap_enter && !trap_return |=> $stable(sr_q)); // R9
endmodule

bind banked_regfile brf_checker #(.SRW(SRW)) u_brf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .sr_wr_en   (sr_wr_en),
  .priv_ok    (priv_ok),
  .trap_enter (trap_enter),
  .trap_irq   (trap_irq),
  .trap_return(trap_return),
  .sr_q       (sr_q),
  .exsr_q     (exsr_q),
  .active_bank(active_bank)
);

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [63:0] rd_a_data, rd_b_data, wr_data, ctl_rd_data, ctl_wr_data;
  logic        wr_en, ctl_wr_en, side_wr_en, sr_wr_en, priv_ok;
  logic [1:0]  ctl_rd_sel, ctl_wr_sel, side_rd_bank, side_wr_bank, active_bank;
  logic [5:0]  side_rd_sel, side_wr_sel;
  logic [63:0] side_rd_data, side_wr_data;
  logic [31:0] sr_wr_data, sr_q, exsr_q;
  logic        trap_enter, trap_irq, trap_return;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [63:0] mdl [4][36];
  logic [31:0] sr_m, ex_m;

  always #4 clk = ~clk;

  banked_regfile u_banked_regfile (.*);

  function automatic logic [63:0] pat(int b, int e, int salt);
    logic [63:0] m;
    m = 64'h9E3779B97F4A7C15 * 64'(b * 64 + e + 1 + salt * 977);
    return {8'(b * 16 + salt), 8'(e), m[47:0]};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; ctl_wr_en = 0; side_wr_en = 0; sr_wr_en = 0; priv_ok = 0;
    trap_enter = 0; trap_irq = 0; trap_return = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic set_sr(logic [31:0] v, bit ok);
    sr_wr_en = 1; sr_wr_data = v; priv_ok = ok;
    cyc(); idle();
    sr_m = ok ? v : ((v & ~32'h000C_0000) | (sr_m & 32'h000C_0000));
  endtask

  task automatic sweep_side(string req);
    for (int b = 0; b < 4; b++)
      for (int e = 0; e < 36; e++) begin
        side_rd_bank = 2'(b); side_rd_sel = 6'(e); #1;
        chk(req, side_rd_data, mdl[b][e]);
      end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0; ctl_rd_sel = 0;
    ctl_wr_sel = 0; ctl_wr_data = 0; side_rd_bank = 0; side_rd_sel = 0;
    side_wr_bank = 0; side_wr_sel = 0; side_wr_data = 0; sr_wr_data = 0;
    rst_n = 0;
    for (int b = 0; b < 4; b++) for (int e = 0; e < 36; e++) mdl[b][e] = '0;
    sr_m = 0; ex_m = 0;
    repeat (3) cyc();
    rst_n = 1; cyc();

    // R1 reset state
    chk("R1 sr", 64'(sr_q), 0);
    chk("R1 exsr", 64'(exsr_q), 0);
    chk("R1 bank", 64'(active_bank), 0);
    sweep_side("R1 entries zero");

    // R2 R3: fill every bank through the normal ports
    for (int b = 0; b < 4; b++) begin
      set_sr(32'(b) << 18, 1);
      chk("R2 bank select", 64'(active_bank), 64'(b));
      for (int i = 0; i < 32; i++) begin
        wr_en = 1; wr_idx = 5'(i); wr_data = pat(b, i, 1);
        cyc(); idle(); mdl[b][i] = pat(b, i, 1);
      end
      for (int c = 0; c < 4; c++) begin
        ctl_wr_en = 1; ctl_wr_sel = 2'(c); ctl_wr_data = pat(b, 32 + c, 1);
        cyc(); idle(); mdl[b][32 + c] = pat(b, 32 + c, 1);
      end
    end
    sweep_side("R4 side read after fill");

    // R2 R3 read back per active bank
    for (int b = 0; b < 4; b++) begin
      set_sr(32'(b) << 18, 1);
      for (int i = 0; i < 32; i++) begin
        rd_a_idx = 5'(i); rd_b_idx = 5'(31 - i); #1;
        chk("R2 port a", rd_a_data, mdl[b][i]);
        chk("R2 port b", rd_b_data, mdl[b][31 - i]);
      end
      for (int c = 0; c < 4; c++) begin
        ctl_rd_sel = 2'(c); #1;
        chk("R3 ctl read", ctl_rd_data, mdl[b][32 + c]);
      end
    end

    // R4 out-of-range codes read 0; writes with them are ignored
    for (int s = 36; s < 64; s++) begin
      side_rd_bank = 2'(s % 4); side_rd_sel = 6'(s); #1;
      chk("R4 high code reads 0", side_rd_data, 0);
    end
    for (int s = 36; s < 64; s++) begin
      side_wr_en = 1; side_wr_bank = 2'(s % 4); side_wr_sel = 6'(s);
      side_wr_data = ~64'(s);
      cyc(); idle();
    end
    sweep_side("R4 high code write ignored");

    // R4 side writes to every entry of every bank, active bank 3
    for (int b = 0; b < 4; b++)
      for (int e = 0; e < 36; e++) begin
        side_wr_en = 1; side_wr_bank = 2'(b); side_wr_sel = 6'(e);
        side_wr_data = pat(b, e, 2);
        cyc(); idle(); mdl[b][e] = pat(b, e, 2);
      end
    sweep_side("R4 side write");

    // R5 side access to the active bank equals normal access
    set_sr(32'h1 << 18, 1);
    side_wr_en = 1; side_wr_bank = 2'd1; side_wr_sel = 6'd7;
    side_wr_data = 64'hDEAD_BEEF_0000_0007;
    cyc(); idle(); mdl[1][7] = 64'hDEAD_BEEF_0000_0007;
    rd_a_idx = 5'd7; #1;
    chk("R5 side write seen on port a", rd_a_data, mdl[1][7]);
    side_wr_en = 1; side_wr_sel = 6'd34; side_wr_data = 64'hC0DE_0000_0000_0022;
    cyc(); idle(); mdl[1][34] = 64'hC0DE_0000_0000_0022;
    ctl_rd_sel = 2'd2; #1;
    chk("R5 side write seen on ctl port", ctl_rd_data, mdl[1][34]);
    wr_en = 1; wr_idx = 5'd9; wr_data = 64'h1234_5678_9ABC_DEF0;
    cyc(); idle(); mdl[1][9] = 64'h1234_5678_9ABC_DEF0;
    side_rd_bank = 2'd1; side_rd_sel = 6'd9; #1;
    chk("R5 normal write seen on side", side_rd_data, mdl[1][9]);

    // R6 same-cycle collisions: normal write wins
    wr_en = 1; wr_idx = 5'd3; wr_data = 64'hAAAA_0000_0000_0003;
    side_wr_en = 1; side_wr_bank = 2'd1; side_wr_sel = 6'd3;
    side_wr_data = 64'h5555_0000_0000_0003;
    cyc(); idle(); mdl[1][3] = 64'hAAAA_0000_0000_0003;
    rd_a_idx = 5'd3; #1;
    chk("R6 gpr collision", rd_a_data, mdl[1][3]);
    ctl_wr_en = 1; ctl_wr_sel = 2'd1; ctl_wr_data = 64'hAAAA_0000_0000_0021;
    side_wr_en = 1; side_wr_bank = 2'd1; side_wr_sel = 6'd33;
    side_wr_data = 64'h5555_0000_0000_0021;
    cyc(); idle(); mdl[1][33] = 64'hAAAA_0000_0000_0021;
    ctl_rd_sel = 2'd1; #1;
    chk("R6 ctl collision", ctl_rd_data, mdl[1][33]);
    sweep_side("R6 no stray writes");

    // R7 guarded bank field
    for (int v = 0; v < 4; v++) begin
      set_sr((32'(v) << 18) | 32'h0000_0A05 | (32'(v) << 24), 0);
      chk("R7 unprivileged sr", 64'(sr_q), 64'(sr_m));
      chk("R7 bank kept", 64'(active_bank), 1);
    end
    set_sr(32'h0008_0A05, 1);
    chk("R7 privileged sr", 64'(sr_q), 64'h0008_0A05);

    // R8 R9 trap entry and return
    trap_enter = 1; trap_irq = 1; cyc(); idle();
    chk("R8 irq exsr", 64'(exsr_q), 64'h0008_0A05);
    chk("R8 irq sr", 64'(sr_q), 64'h000C_0A05);
    trap_return = 1; cyc(); idle();
    chk("R9 return sr", 64'(sr_q), 64'h0008_0A05);
    set_sr(32'h0000_0F00, 1);
    trap_enter = 1; trap_irq = 0; trap_return = 1; sr_wr_en = 1;
    sr_wr_data = 32'h000C_0000; priv_ok = 1; cyc(); idle();
    chk("R9 enter wins exsr", 64'(exsr_q), 64'h0000_0F00);
    chk("R8 syscall sr", 64'(sr_q), 64'h0008_0F00);
    trap_return = 1; sr_wr_en = 1; sr_wr_data = 32'h0004_0000; priv_ok = 1;
    cyc(); idle();
    chk("R9 return wins over write", 64'(sr_q), 64'h0000_0F00);
    sr_m = 32'h0000_0F00;

    // R10 write during bank change commits to the old bank
    wr_en = 1; wr_idx = 5'd4; wr_data = 64'hB0B0_0000_0000_0004;
    ctl_wr_en = 1; ctl_wr_sel = 2'd3; ctl_wr_data = 64'hB0B0_0000_0000_0023;
    sr_wr_en = 1; sr_wr_data = 32'h0004_0000; priv_ok = 1;
    cyc(); idle(); sr_m = 32'h0004_0000;
    mdl[0][4] = 64'hB0B0_0000_0000_0004; mdl[0][35] = 64'hB0B0_0000_0000_0023;
    chk("R10 bank switched", 64'(active_bank), 1);
    side_rd_bank = 2'd0; side_rd_sel = 6'd4; #1;
    chk("R10 old bank written", side_rd_data, mdl[0][4]);
    rd_a_idx = 5'd4; #1;
    chk("R10 new bank untouched", rd_a_data, mdl[1][4]);
    sweep_side("R10 full sweep");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule